// File: doc/BRIEF.md
# Memory card presence responder

This block plays the card's part in a byte-wide serial exchange with a console. While the host holds the select line, it sends one byte per exchange. The first byte of a frame is an address, and the card returns exactly one reply byte for every byte it receives.

When a card is inserted and the address byte is 0x81, the card answers with a four-byte presence frame. The first byte of that frame is a start-up flag. The flag steps through a short fixed sequence on successive accesses after insertion, so software can tell that a card has just been swapped in.

With no card inserted, the line stays idle: every reply is 0xFF and no acknowledge is produced. Sector commands and the storage itself are handled elsewhere.

Top module: `mc_presence_resp`

## Requirements
- R1: After reset, `tx_valid` and `ack` are low and `tx_byte` is 0xFF.
- R2: While `inserted` is low, every received byte is answered with 0xFF and `ack` stays low.
- R3: With a card inserted, the replies to address 0x81 and the three bytes that follow are, in order: the flag byte, 0x00, 0x5A and 0x5D. Each reply appears on `tx_byte` with a one-cycle `tx_valid` pulse in the cycle after the `rx_valid` strobe.
- R4: The flag byte is 0x04 on the first 0x81 access after insertion and 0x08 on the second. It is 0x00 on the third and on every later access.
- R5: Taking `inserted` low resets the flag sequence, so the first access after the next insertion again answers 0x04.
- R6: `ack` pulses together with each reply of a presence frame except the final 0x5D. `ack` is never raised with a 0xFF reply.
- R7: An address byte other than 0x81 is answered with 0xFF and no acknowledge. Every later byte of that frame is answered with 0xFF and no acknowledge until select drops.
- R8: Bytes received after the 0x5D of a frame are answered with 0xFF and no acknowledge.
- R9: A strobe received while `sel` is low gets no reply. Dropping `sel` aborts any frame in progress, and the next selected byte is treated as an address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel | input | 1 | Host select, high during a frame |
| inserted | input | 1 | High while a card is present |
| rx_valid | input | 1 | One-cycle strobe: a byte from the host is on rx_byte |
| rx_byte | input | 8 | Byte from the host |
| tx_valid | output | 1 | One-cycle strobe: reply on tx_byte |
| tx_byte | output | 8 | Reply byte to the host |
| ack | output | 1 | Acknowledge pulse, asks the host for the next byte |

## Verification
The bench walks the flag through 0x04, 0x08 and 0x00 across three separate frames. A design whose counter wraps instead of saturating would answer 0x04 again on a later access. It removes the card between frames and expects 0x04 on the next access; a design that kept the count across a swap would answer 0x00 there.

It also sends a wrong address, extra bytes after the 0x5D, and strobes with select low. A design that drifted into the frame after a bad address, acknowledged the last byte, or answered an unselected strobe would show a wrong byte or a stray `ack`. An abort after the address byte must leave the next frame starting from its address again.

// File: rtl/mc_presence_resp.sv
module mc_presence_resp #(
  parameter int          DW       = 8,
  parameter logic [7:0]  ADDR     = 8'h81,
  parameter logic [7:0]  FLAG_A   = 8'h04,
  parameter logic [7:0]  FLAG_B   = 8'h08,
  parameter logic [7:0]  FLAG_C   = 8'h00,
  parameter logic [7:0]  BODY_1   = 8'h00,
  parameter logic [7:0]  BODY_2   = 8'h5A,
  parameter logic [7:0]  BODY_3   = 8'h5D
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sel,
  input  logic          inserted,
  input  logic          rx_valid,
  input  logic [DW-1:0] rx_byte,
  output logic          tx_valid,
  output logic [DW-1:0] tx_byte,
  output logic          ack
);
  localparam logic [DW-1:0] IDLE = {DW{1'b1}};
  localparam logic [1:0]    LAST = 2'd3;

  logic [1:0] pos;
  logic       done;
  logic [1:0] boot;

  wire take    = rx_valid && sel;
  wire live    = inserted && !done;
  wire addr_ok = (pos == 2'd0) && (rx_byte == ADDR);
  wire accept  = live && ((pos != 2'd0) || addr_ok);

  logic [DW-1:0] flag;
  logic [DW-1:0] reply;

  always_comb begin
    case (boot)
      2'd0:    flag = FLAG_A;
      2'd1:    flag = FLAG_B;
      default: flag = FLAG_C;
    endcase
  end

  always_comb begin
    reply = IDLE;
    if (accept) begin
      case (pos)
        2'd0:    reply = flag;
        2'd1:    reply = BODY_1;
        2'd2:    reply = BODY_2;
        default: reply = BODY_3;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos  <= 2'd0;
      done <= 1'b0;
    end else if (!sel) begin
      pos  <= 2'd0;
      done <= 1'b0;
    end else if (take) begin
      if (!accept || pos == LAST) done <= 1'b1;
      else                        pos  <= pos + 2'd1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !inserted)
      boot <= 2'd0;
    else if (take && accept && pos == 2'd0 && boot != 2'd2)
      boot <= boot + 2'd1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_valid <= 1'b0;
      tx_byte  <= IDLE;
      ack      <= 1'b0;
    end else begin
      tx_valid <= take;
      ack      <= take && accept && (pos != LAST);
      if (take) tx_byte <= reply;
    end
  end
endmodule

module mc_presence_resp_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sel,
  input logic       inserted,
  input logic       tx_valid,
  input logic [7:0] tx_byte,
  input logic       ack
);
  AST_NO_ACK_ABSENT: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> $past(inserted)); // R2
  AST_ABSENT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !$past(inserted)) |-> tx_byte == 8'hFF); // R2
  AST_ACK_WITH_REPLY: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> tx_valid); // R6
  AST_NO_ACK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_byte == 8'hFF) |-> !ack); // R6
  AST_LAST_NO_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_byte == 8'h5D) |-> !ack); // R6
  AST_UNSEL_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(sel) |-> !tx_valid); // R9
endmodule

bind mc_presence_resp mc_presence_resp_chk chk_i (
  .clk(clk), .rst_n(rst_n), .sel(sel), .inserted(inserted),
  .tx_valid(tx_valid), .tx_byte(tx_byte), .ack(ack)
);

// File: tb/mc_presence_resp_tb_top.sv
`timescale 1ns/1ps
module mc_presence_resp_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sel = 1'b0;
  logic       inserted = 1'b0;
  logic       rx_valid = 1'b0;
  logic [7:0] rx_byte = 8'h00;
  logic       tx_valid;
  logic [7:0] tx_byte;
  logic       ack;

  int tests = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  mc_presence_resp dut_i (
    .clk(clk), .rst_n(rst_n), .sel(sel), .inserted(inserted),
    .rx_valid(rx_valid), .rx_byte(rx_byte),
    .tx_valid(tx_valid), .tx_byte(tx_byte), .ack(ack)
  );

  // {new_frame, inserted, byte_in, expected_reply, expected_ack}
  localparam int NV = 17;
  localparam logic [18:0] VEC [NV] = '{
    {1'b1, 1'b1, 8'h81, 8'h04, 1'b1},  // R3 R4 first access
    {1'b0, 1'b1, 8'h42, 8'h00, 1'b1},  // R3
    {1'b0, 1'b1, 8'h00, 8'h5A, 1'b1},  // R3
    {1'b0, 1'b1, 8'h00, 8'h5D, 1'b0},  // R6 last byte no ack
    {1'b0, 1'b1, 8'h00, 8'hFF, 1'b0},  // R8
    {1'b1, 1'b1, 8'h81, 8'h08, 1'b1},  // R4 second access
    {1'b0, 1'b1, 8'h00, 8'h00, 1'b1},
    {1'b0, 1'b1, 8'h00, 8'h5A, 1'b1},
    {1'b0, 1'b1, 8'h00, 8'h5D, 1'b0},
    {1'b1, 1'b1, 8'h81, 8'h00, 1'b1},  // R4 third access
    {1'b1, 1'b1, 8'h81, 8'h00, 1'b1},  // R9 abort then new address
    {1'b1, 1'b1, 8'h23, 8'hFF, 1'b0},  // R7 bad address
    {1'b0, 1'b1, 8'h81, 8'hFF, 1'b0},  // R7 rest of frame idle
    {1'b1, 1'b0, 8'h81, 8'hFF, 1'b0},  // R2 absent
    {1'b0, 1'b0, 8'h00, 8'hFF, 1'b0},  // R2
    {1'b1, 1'b1, 8'h81, 8'h04, 1'b1},  // R5 restart after removal
    {1'b1, 1'b1, 8'h81, 8'h08, 1'b1}   // R5 R4
  };

  task automatic check(input string req, input logic [8:0] act, input logic [8:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got {valid,byte}/ack=%h expected %h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic [7:0] b, output logic v, output logic [7:0] r, output logic a);
    @(negedge clk);
    rx_byte  = b;
    rx_valid = 1'b1;
    @(negedge clk);
    rx_valid = 1'b0;
    v = tx_valid;
    r = tx_byte;
    a = ack;
  endtask

  task automatic new_frame(input logic ins);
    @(negedge clk);
    sel = 1'b0;
    inserted = ins;
    @(negedge clk);
    sel = 1'b1;
  endtask

  initial begin
    logic v, a;
    logic [7:0] r;
    repeat (3) @(negedge clk);
    check("R1 reset", {tx_valid, tx_byte}, {1'b0, 8'hFF});
    check("R1 reset ack", {8'h00, ack}, 9'h000);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][18]) new_frame(VEC[i][17]);
      else inserted = VEC[i][17];
      xfer(VEC[i][16:9], v, r, a);
      check($sformatf("vector %0d reply", i), {v, r}, {1'b1, VEC[i][8:1]});
      check($sformatf("vector %0d ack (R6)", i), {8'h00, a}, {8'h00, VEC[i][0]});
    end

    // R9: strobe with select low gives no reply
    @(negedge clk);
    sel = 1'b0;
    xfer(8'h81, v, r, a);
    check("R9 unselected strobe", {v, 7'h00, a}, 9'h000);

    // R9: abort after address, reselect, next byte is an address again
    new_frame(1'b1);
    xfer(8'h81, v, r, a);
    check("R9 abort address", {v, r}, {1'b1, 8'h00});
    new_frame(1'b1);
    xfer(8'h00, v, r, a);
    check("R9 non-address after abort is bad address (R7)", {v, r}, {1'b1, 8'hFF});
    check("R9 no ack after abort", {8'h00, a}, 9'h000);

    // R2: card pulled mid-frame
    new_frame(1'b1);
    xfer(8'h81, v, r, a);
    inserted = 1'b0;
    xfer(8'h00, v, r, a);
    check("R2 removed mid-frame", {v, r, a}, {1'b1, 8'hFF, 1'b0});

    // R5: reinsertion restarts the flag at 0x04
    new_frame(1'b1);
    xfer(8'h81, v, r, a);
    check("R5 reinsertion flag", {v, r}, {1'b1, 8'h04});

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      tests++;
      fails++;
      $display("FAIL watchdog: got running expected finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule